// File: doc/BRIEF.md
# Banked SDRAM Command Sequencer

This block sits between a simple request port and a multi-bank synchronous DRAM device. Each accepted request names an address and a direction. The block cuts the address into a bank number, a row and a column. It then issues the activate, precharge and column commands that the device needs, and it respects the device's cycle timing. A row stays open in its bank after an access. A later access to that same row therefore needs only a column command. An access to a different row in the same bank first closes the old row.

The sequencer holds one request at a time. Column traffic has to wait for the shared data bus, but activate and precharge commands do not. The next request can therefore open a row in another bank while the previous burst is still moving data. One column command moves a burst of several words. Write words go out on the data bus starting in the cycle of the write command. Read words come back on a strobed output in column order.

A refresh timer runs from reset. Its interval is the retention window divided by the row count, and a parameter can divide it further to shorten simulations. When the timer fires, the block closes every bank and issues a refresh before it takes new work. A level input puts the block into a low-power state. In that state the device clock enable is dropped and no commands go out, but the block still leaves that state briefly to refresh on schedule.

Top module: `sdram_seq`

## Requirements
- R1: The request address is read with the bank number in the most significant BANK_W bits, the row in the next ROW_W bits and the column in the least significant COL_W bits.
- R2: For a bank with no open row, the block issues an activate carrying the row on `dram_addr`. It then issues a read or write carrying the column on `dram_addr`. Command codes on `dram_cmd` are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh.
- R3: An access to the row already open in its bank issues only the column command, with no activate and no precharge.
- R4: An access to a different row in a bank that has a row open first issues a precharge to that bank, then an activate. A bank never holds more than one open row.
- R5: A column command comes at least TRCD cycles after the activate to its bank. A precharge comes at least TRAS cycles after that activate. An activate comes at least TRP cycles after the precharge to its bank, and at least TRFC cycles after a refresh.
- R6: Activate and precharge commands to one bank may be issued while a burst on another bank still occupies the data bus. An activate for a closed bank follows the preceding write command by fewer than BL cycles when the two requests arrive back to back.
- R7: One column command moves BL words to columns col, col+1, … modulo the row length. Write word i is bits [i*DW +: DW] of `req_wdata` and is driven with `dram_dq_oe` high in the i-th cycle from the write command. Read words appear on `rd_data` with `rd_valid` high for BL consecutive cycles, in that column order. The device returns read word i in the (i+1)-th cycle after the read command.
- R8: Refresh commands are issued at intervals of RET_MS·1000·CLK_MHZ / 2^ROW_W / SIM_DIV cycles, plus a bounded service delay. Every bank is closed before a refresh, and `req_ready` is low while a refresh is under way.
- R9: A due refresh is served before any new request is accepted, so a continuous stream of requests cannot delay refresh beyond the bound.
- R10: While `pd_req` is high and the block is idle, `dram_cke` is low, only no-ops are issued and `req_ready` is low. Refreshes still occur on schedule, and stored data is intact afterwards.
- R11: During and after reset, `dram_cmd` is no-op, `dram_cke` is high, `rd_valid` is low, and `req_ready` is high once reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid is also high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | BANK_W+ROW_W+COL_W | Bank, row, column |
| req_wdata | input | BL*DW | Write burst, word 0 in the lowest bits |
| pd_req | input | 1 | Low-power request (level) |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word |
| dram_cke | output | 1 | Device clock enable |
| dram_cmd | output | 3 | Device command code |
| dram_bank | output | BANK_W | Command bank |
| dram_addr | output | max(ROW_W,COL_W) | Row or column |
| dram_dq_out | output | DW | Write data |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | DW | Read data from device |

## Verification
The hardest case to reach is a refresh that falls due while requests keep arriving without a gap. There the refresh must win over the next request and still close banks whose activate timers have not run out. The bench streams more than a hundred back-to-back reads across several refresh intervals. Its device model bounds every refresh gap and rejects any refresh issued while a bank is open. The cross-bank overlap case needs a fresh refresh boundary, so the bench waits for a refresh before sending a write and a read to a closed bank back to back. It then measures the distance from the write command to the activate.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_REF  = 3'd2,
        ST_RFC  = 3'd3,
        ST_PD   = 3'd4
    } seq_st_e;

endpackage

// File: rtl/sdseq_bank.sv
module sdseq_bank #(
    parameter int ROW_W = 8,
    parameter int TRCD  = 2,
    parameter int TRP   = 2,
    parameter int TRAS  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o
);
    localparam int TMAX = (TRAS > TRCD) ? ((TRAS > TRP) ? TRAS : TRP)
                                        : ((TRCD > TRP) ? TRCD : TRP);
    localparam int CW = $clog2(TMAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    rcd;
        logic [CW-1:0]    ras;
        logic [CW-1:0]    rp;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (bank_q.rcd != '0) bank_d.rcd = bank_q.rcd - 1'b1;
        if (bank_q.ras != '0) bank_d.ras = bank_q.ras - 1'b1;
        if (bank_q.rp  != '0) bank_d.rp  = bank_q.rp  - 1'b1;
        if (act_i) begin
            bank_d.open = 1'b1;
            bank_d.row  = row_i;
            bank_d.rcd  = CW'(TRCD - 1);
            bank_d.ras  = CW'(TRAS - 1);
        end else if (pre_i) begin
            bank_d.open = 1'b0;
            bank_d.rp   = CW'(TRP - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign open_o   = bank_q.open;
    assign row_o    = bank_q.row;
    assign col_ok_o = bank_q.open && (bank_q.rcd == '0);
    assign pre_ok_o = bank_q.open && (bank_q.ras == '0);
    assign act_ok_o = !bank_q.open && (bank_q.rp == '0);
endmodule

// File: rtl/sdseq_reftimer.sv
module sdseq_reftimer #(
    parameter int PERIOD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic due_o
);
    localparam int P  = (PERIOD < 1) ? 1 : PERIOD;
    localparam int TW = $clog2(P + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == '0) begin
            tmr_d.cnt = TW'(P - 1);
            tmr_d.due = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
        if (clr_i) tmr_d.due = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= TW'(P - 1);
            tmr_q.due <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign due_o = tmr_q.due;
endmodule

// File: rtl/sdseq_rdret.sv
module sdseq_rdret #(
    parameter int DW = 16,
    parameter int BL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dq_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    localparam int BLC = $clog2(BL + 1);

    typedef struct packed {
        logic           dly;
        logic [BLC-1:0] cnt;
        logic           valid;
        logic [DW-1:0]  data;
    } ret_t;

    ret_t ret_d, ret_q;

    always_comb begin
        ret_d       = ret_q;
        ret_d.valid = 1'b0;
        if (ret_q.dly) begin
            ret_d.dly = 1'b0;
        end else if (ret_q.cnt != '0) begin
            ret_d.valid = 1'b1;
            ret_d.data  = dq_i;
            ret_d.cnt   = ret_q.cnt - 1'b1;
        end
        if (start_i) begin
            ret_d.dly = 1'b1;
            ret_d.cnt = BLC'(BL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ret_q <= '0;
        else        ret_q <= ret_d;
    end

    assign valid_o = ret_q.valid;
    assign data_o  = ret_q.data;
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdseq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 4,
    parameter int BL      = 4,
    parameter int TRCD    = 2,
    parameter int TRP     = 2,
    parameter int TRAS    = 5,
    parameter int TRFC    = 6,
    parameter int CLK_MHZ = 100,
    parameter int RET_MS  = 64,
    parameter int SIM_DIV = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
    input  logic [BL*DW-1:0]                req_wdata,
    input  logic                            pd_req,
    output logic                            rd_valid,
    output logic [DW-1:0]                   rd_data,
    output logic                            dram_cke,
    output logic [2:0]                      dram_cmd,
    output logic [BANK_W-1:0]               dram_bank,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
    output logic [DW-1:0]                   dram_dq_out,
    output logic                            dram_dq_oe,
    input  logic [DW-1:0]                   dram_dq_in
);
    localparam int NB      = 1 << BANK_W;
    localparam int ADDR_W  = BANK_W + ROW_W + COL_W;
    localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int BLC     = $clog2(BL + 1);
    localparam int RFCW    = $clog2(TRFC + 1);
    localparam int REF_CYC = RET_MS * 1000 * CLK_MHZ / (1 << ROW_W) / SIM_DIV;

    typedef struct packed {
        seq_st_e           st;
        dcmd_e             cmd;
        logic              cke;
        logic [BANK_W-1:0] bank;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     dq;
        logic              oe;
        logic [BL*DW-1:0]  wbuf;
        logic [BLC-1:0]    wleft;
        logic [BLC-1:0]    bus_cnt;
        logic [BANK_W-1:0] last_bank;
        logic              cur_wr;
        logic [BANK_W-1:0] cur_bank;
        logic [ROW_W-1:0]  cur_row;
        logic [COL_W-1:0]  cur_col;
        logic [BL*DW-1:0]  cur_wdata;
        logic [RFCW-1:0]   rfc;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, cmd: CMD_NOP, cke: 1'b1, default: '0};

    seq_t seq_d, seq_q;

    logic [NB-1:0]    b_open, b_colok, b_preok, b_actok, b_busy;
    logic [NB-1:0]    act_vec, pre_vec;
    logic [ROW_W-1:0] b_row [NB];
    logic             ref_due;
    logic             bus_free;

    // one tracker per bank
    for (genvar g = 0; g < NB; g++) begin : g_bank
        sdseq_bank #(
            .ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_vec[g]),
            .pre_i    (pre_vec[g]),
            .row_i    (seq_d.addr[ROW_W-1:0]),
            .open_o   (b_open[g]),
            .row_o    (b_row[g]),
            .col_ok_o (b_colok[g]),
            .pre_ok_o (b_preok[g]),
            .act_ok_o (b_actok[g])
        );
    end

    sdseq_reftimer #(.PERIOD(REF_CYC)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (seq_d.cmd == CMD_REF),
        .due_o (ref_due)
    );

    sdseq_rdret #(.DW(DW), .BL(BL)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (seq_d.cmd == CMD_RD),
        .dq_i    (dram_dq_in),
        .valid_o (rd_valid),
        .data_o  (rd_data)
    );

    assign bus_free  = (seq_q.bus_cnt == '0);
    assign req_ready = (seq_q.st == ST_IDLE) && !ref_due && !pd_req;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            b_busy[b]  = !bus_free && (seq_q.last_bank == BANK_W'(b));
            act_vec[b] = (seq_d.cmd == CMD_ACT) && (seq_d.bank == BANK_W'(b));
            pre_vec[b] = (seq_d.cmd == CMD_PRE) && (seq_d.bank == BANK_W'(b));
        end
    end

    always_comb begin
        logic [BANK_W-1:0] cb;
        logic              found;
        seq_d     = seq_q;
        seq_d.cmd = CMD_NOP;
        seq_d.cke = 1'b1;
        cb        = seq_q.cur_bank;
        found     = 1'b0;

        if (!bus_free) seq_d.bus_cnt = seq_q.bus_cnt - 1'b1;

        // write beats after the first
        if (seq_q.wleft != '0) begin
            seq_d.dq    = seq_q.wbuf[DW-1:0];
            seq_d.oe    = 1'b1;
            seq_d.wbuf  = seq_q.wbuf >> DW;
            seq_d.wleft = seq_q.wleft - 1'b1;
        end else begin
            seq_d.dq = '0;
            seq_d.oe = 1'b0;
        end

        case (seq_q.st)
            ST_IDLE: begin
                if (ref_due) begin
                    seq_d.st = ST_REF;
                end else if (pd_req) begin
                    if (bus_free) begin
                        seq_d.st  = ST_PD;
                        seq_d.cke = 1'b0;
                    end
                end else if (req_valid) begin
                    seq_d.st        = ST_RUN;
                    seq_d.cur_wr    = req_write;
                    seq_d.cur_bank  = req_addr[ADDR_W-1 -: BANK_W];
                    seq_d.cur_row   = req_addr[COL_W +: ROW_W];
                    seq_d.cur_col   = req_addr[COL_W-1:0];
                    seq_d.cur_wdata = req_wdata;
                end
            end
            ST_RUN: begin
                if (b_open[cb] && (b_row[cb] == seq_q.cur_row)) begin
                    if (b_colok[cb] && bus_free) begin
                        seq_d.cmd       = seq_q.cur_wr ? CMD_WR : CMD_RD;
                        seq_d.bank      = cb;
                        seq_d.addr      = AW'(seq_q.cur_col);
                        seq_d.bus_cnt   = BLC'(BL);
                        seq_d.last_bank = cb;
                        seq_d.st        = ST_IDLE;
                        if (seq_q.cur_wr) begin
                            seq_d.dq    = seq_q.cur_wdata[DW-1:0];
                            seq_d.oe    = 1'b1;
                            seq_d.wbuf  = seq_q.cur_wdata >> DW;
                            seq_d.wleft = BLC'(BL - 1);
                        end
                    end
                end else if (b_open[cb]) begin
                    if (b_preok[cb] && !b_busy[cb]) begin
                        seq_d.cmd  = CMD_PRE;
                        seq_d.bank = cb;
                    end
                end else if (b_actok[cb]) begin
                    seq_d.cmd  = CMD_ACT;
                    seq_d.bank = cb;
                    seq_d.addr = AW'(seq_q.cur_row);
                end
            end
            ST_REF: begin
                for (int b = 0; b < NB; b++) begin
                    if (!found && b_open[b] && b_preok[b] && !b_busy[b]) begin
                        found      = 1'b1;
                        seq_d.cmd  = CMD_PRE;
                        seq_d.bank = BANK_W'(b);
                    end
                end
                if (!found && (b_open == '0) && (&b_actok) && bus_free) begin
                    seq_d.cmd = CMD_REF;
                    seq_d.rfc = RFCW'(TRFC - 1);
                    seq_d.st  = ST_RFC;
                end
            end
            ST_RFC: begin
                if (seq_q.rfc == '0) seq_d.st = ST_IDLE;
                else                 seq_d.rfc = seq_q.rfc - 1'b1;
            end
            ST_PD: begin
                if (ref_due) begin
                    seq_d.st = ST_REF;
                end else if (!pd_req) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cke = 1'b0;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign dram_cke    = seq_q.cke;
    assign dram_cmd    = seq_q.cmd;
    assign dram_bank   = seq_q.bank;
    assign dram_addr   = seq_q.addr;
    assign dram_dq_out = seq_q.dq;
    assign dram_dq_oe  = seq_q.oe;
endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker
    import sdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int TRCD   = 2,
    parameter int BL     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        dram_cmd,
    input logic [BANK_W-1:0] dram_bank,
    input logic              dram_cke,
    input logic              dram_dq_oe,
    input logic              req_ready,
    input logic              rd_valid
);
    localparam int NB    = 1 << BANK_W;
    localparam int AGE_W = $clog2(TRCD + 2);

    logic [NB-1:0]    open_q;
    logic [AGE_W-1:0] age_q [NB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int b = 0; b < NB; b++) age_q[b] <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (dram_cmd == CMD_ACT && dram_bank == BANK_W'(b)) begin
                    open_q[b] <= 1'b1;
                    age_q[b]  <= AGE_W'(1);
                end else begin
                    if (dram_cmd == CMD_PRE && dram_bank == BANK_W'(b)) open_q[b] <= 1'b0;
                    if (age_q[b] < AGE_W'(TRCD)) age_q[b] <= age_q[b] + 1'b1;
                end
            end
        end
    end

    assert_col_after_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == CMD_RD || dram_cmd == CMD_WR) |-> (open_q[dram_bank] && age_q[dram_bank] >= AGE_W'(TRCD)));

    assert_act_closed_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == CMD_ACT) |-> !open_q[dram_bank]);

    assert_ref_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == CMD_REF) |-> (open_q == '0));

    assert_ref_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == CMD_REF) |-> !req_ready);

    assert_pd_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cke |-> (dram_cmd == CMD_NOP));

    assert_wr_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == CMD_WR) |-> dram_dq_oe);

    assert_rd_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);
endmodule

bind sdram_seq sdseq_checker #(
    .BANK_W (BANK_W),
    .TRCD   (TRCD),
    .BL     (BL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_cmd   (dram_cmd),
    .dram_bank  (dram_bank),
    .dram_cke   (dram_cke),
    .dram_dq_oe (dram_dq_oe),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid)
);

// File: tb/sim_sdram_seq.sv
module sim_sdram_seq;
    localparam int DW = 16, BANK_W = 2, ROW_W = 8, COL_W = 4, BL = 4;
    localparam int TRCD = 2, TRP = 2, TRAS = 5, TRFC = 6, SIM_DIV = 100;
    localparam int NCOL = 1 << COL_W;
    localparam int REF_CYC = 64 * 1000 * 100 / 256 / SIM_DIV;
    localparam int MARGIN = 40;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, pd_req = 1'b0;
    logic req_ready;
    logic [BANK_W+ROW_W+COL_W-1:0] req_addr = '0;
    logic [BL*DW-1:0] req_wdata = '0;
    logic rd_valid, dram_cke, dram_dq_oe;
    logic [DW-1:0] rd_data, dram_dq_out;
    logic [DW-1:0] dram_dq_in = '0;
    logic [2:0] dram_cmd;
    logic [BANK_W-1:0] dram_bank;
    logic [AW-1:0] dram_addr;

    always #5 clk = ~clk;

    sdram_seq #(.DW(DW), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BL(BL),
                .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRFC(TRFC), .SIM_DIV(SIM_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .pd_req(pd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_cke(dram_cke), .dram_cmd(dram_cmd),
        .dram_bank(dram_bank), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

    int n_chk = 0, n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int key(input int b, input int r, input int c);
        return (b << 12) | (r << 4) | (c % NCOL);
    endfunction

    // ---------------- device model ----------------
    logic [DW-1:0] mem [int];
    logic [DW-1:0] shadow [int];
    bit     m_open [4];
    int     m_row [4];
    longint m_act_t [4], m_pre_t [4];
    longint m_ref_t = 0, m_wr_t = 0;
    int n_act = 0, n_pre = 0, n_ref = 0;
    int last_act_bank = -1, last_act_row = -1, last_col = -1;
    int rd_left = 0, rd_b = 0, rd_r = 0, rd_c = 0;
    int wr_left = 0, wr_b = 0, wr_r = 0, wr_c = 0;

    function automatic logic [DW-1:0] mget(input int k);
        if (mem.exists(k)) return mem[k];
        return '0;
    endfunction

    initial for (int b = 0; b < 4; b++) begin
        m_open[b] = 0; m_row[b] = 0; m_act_t[b] = -100; m_pre_t[b] = -100;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_left > 0) begin
                dram_dq_in = mget(key(rd_b, rd_r, rd_c));
                rd_c = (rd_c + 1) % NCOL; rd_left--;
            end
            if (wr_left > 0) begin
                chk(dram_dq_oe, "R7", "write beat drive", dram_dq_oe, 1);
                mem[key(wr_b, wr_r, wr_c)] = dram_dq_out;
                wr_c = (wr_c + 1) % NCOL; wr_left--;
            end
            if (!dram_cke)
                chk(dram_cmd == 3'd0, "R10", "command with clock disabled", dram_cmd, 0);
            case (dram_cmd)
                3'd1: begin
                    chk(!m_open[dram_bank], "R4", "activate on open bank", m_open[dram_bank], 0);
                    chk(cyc - m_pre_t[dram_bank] >= TRP, "R5", "precharge to activate", cyc - m_pre_t[dram_bank], TRP);
                    chk(cyc - m_ref_t >= TRFC, "R5", "refresh to activate", cyc - m_ref_t, TRFC);
                    m_open[dram_bank] = 1; m_row[dram_bank] = int'(dram_addr);
                    m_act_t[dram_bank] = cyc; n_act++;
                    last_act_bank = int'(dram_bank); last_act_row = int'(dram_addr);
                end
                3'd2, 3'd3: begin
                    chk(m_open[dram_bank], "R2", "column on closed bank", m_open[dram_bank], 1);
                    chk(cyc - m_act_t[dram_bank] >= TRCD, "R5", "activate to column", cyc - m_act_t[dram_bank], TRCD);
                    chk(rd_left == 0 && wr_left == 0, "R7", "bus overlap", rd_left + wr_left, 0);
                    last_col = int'(dram_addr);
                    if (dram_cmd == 3'd2) begin
                        rd_left = BL; rd_b = dram_bank; rd_r = m_row[dram_bank]; rd_c = int'(dram_addr);
                    end else begin
                        chk(dram_dq_oe, "R7", "first write beat", dram_dq_oe, 1);
                        mem[key(dram_bank, m_row[dram_bank], int'(dram_addr))] = dram_dq_out;
                        wr_left = BL - 1; wr_b = dram_bank; wr_r = m_row[dram_bank];
                        wr_c = (int'(dram_addr) + 1) % NCOL; m_wr_t = cyc;
                    end
                end
                3'd4: begin
                    chk(m_open[dram_bank], "R4", "precharge closed bank", m_open[dram_bank], 1);
                    chk(cyc - m_act_t[dram_bank] >= TRAS, "R5", "activate to precharge", cyc - m_act_t[dram_bank], TRAS);
                    chk(!((rd_left > 0 && rd_b == dram_bank) || (wr_left > 0 && wr_b == dram_bank)),
                        "R5", "precharge during own burst", rd_left + wr_left, 0);
                    m_open[dram_bank] = 0; m_pre_t[dram_bank] = cyc; n_pre++;
                end
                3'd5: begin
                    for (int b = 0; b < 4; b++) begin
                        chk(!m_open[b], "R8", "refresh with open bank", b, -1);
                        chk(cyc - m_pre_t[b] >= TRP, "R8", "precharge to refresh", cyc - m_pre_t[b], TRP);
                    end
                    chk(!req_ready, "R8", "ready during refresh", req_ready, 0);
                    chk(cyc - m_ref_t <= REF_CYC + MARGIN, "R8", "refresh gap", cyc - m_ref_t, REF_CYC + MARGIN);
                    m_ref_t = cyc; n_ref++;
                end
                default: ;
            endcase
        end
    end

    // ---------------- scoreboard ----------------
    logic [DW-1:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R7", "unexpected read word", rd_data, -1);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R7", "read word", rd_data, e);
            end
        end
    end

    task automatic send(input bit wr, input int b, input int r, input int c,
                        input logic [BL*DW-1:0] wd);
        req_valid = 1'b1; req_write = wr;
        req_addr  = {BANK_W'(b), ROW_W'(r), COL_W'(c)};
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < BL; i++) begin
            if (wr) shadow[key(b, r, c + i)] = wd[i*DW +: DW];
            else exp_q.push_back(shadow.exists(key(b, r, c + i)) ? shadow[key(b, r, c + i)] : '0);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ref();
        int r0;
        r0 = n_ref;
        while (n_ref == r0) @(negedge clk);
        settle(TRFC + 2);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int a0, p0, r0;
        // R11 reset state
        settle(4);
        chk(dram_cmd == 3'd0, "R11", "cmd in reset", dram_cmd, 0);
        chk(dram_cke == 1'b1, "R11", "cke in reset", dram_cke, 1);
        chk(rd_valid == 1'b0, "R11", "rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        settle(2);
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);

        // R1, R2: closed bank, field split
        a0 = n_act;
        send(1, 2, 8'h5A, 7, 64'h1111_2222_3333_4444);
        settle(16);
        chk(n_act - a0 == 1, "R2", "one activate", n_act - a0, 1);
        chk(last_act_bank == 2, "R1", "bank field", last_act_bank, 2);
        chk(last_act_row == 8'h5A, "R1", "row field", last_act_row, 8'h5A);
        chk(last_col == 7, "R1", "column field", last_col, 7);

        // R3 row hit
        send(1, 0, 3, 0, 64'hA003_A002_A001_A000);
        settle(16);
        a0 = n_act; p0 = n_pre;
        send(0, 0, 3, 0, '0);
        settle(16);
        chk(n_act == a0, "R3", "no activate on hit", n_act - a0, 0);
        chk(n_pre == p0, "R3", "no precharge on hit", n_pre - p0, 0);

        // R4 row miss in same bank, back to back
        a0 = n_act; p0 = n_pre;
        send(1, 0, 9, 4, 64'hB003_B002_B001_B000);
        send(0, 0, 3, 0, '0);
        settle(24);
        chk(n_pre - p0 >= 2, "R4", "precharges on two misses", n_pre - p0, 2);
        chk(n_act - a0 >= 2, "R4", "activates on two misses", n_act - a0, 2);

        // R7 wrap at end of row
        send(1, 1, 2, 14, 64'hC003_C002_C001_C000);
        send(0, 1, 2, 14, '0);
        settle(20);
        chk(mget(key(1, 2, 0)) == 16'hC002, "R7", "wrapped word 2", mget(key(1, 2, 0)), 16'hC002);
        chk(mget(key(1, 2, 1)) == 16'hC003, "R7", "wrapped word 3", mget(key(1, 2, 1)), 16'hC003);

        // R6 overlap: activate on another bank during write burst
        wait_ref();
        send(1, 0, 9, 8, 64'hD003_D002_D001_D000);
        send(0, 3, 7, 0, '0);
        settle(20);
        chk(m_act_t[3] > m_wr_t && m_act_t[3] - m_wr_t < BL, "R6", "activate to write distance",
            m_act_t[3] - m_wr_t, BL - 1);

        // R9 refresh priority under a continuous stream
        r0 = n_ref;
        for (int i = 0; i < 120; i++) send(0, 0, 9, i % NCOL, '0);
        settle(20);
        chk(n_ref - r0 >= 2, "R9", "refreshes during stream", n_ref - r0, 2);

        // R10 power-down with refresh
        send(0, 0, 9, 4, '0);
        settle(16);
        pd_req = 1'b1;
        settle(3);
        chk(dram_cke == 1'b0, "R10", "cke low", dram_cke, 0);
        chk(req_ready == 1'b0, "R10", "ready low", req_ready, 0);
        r0 = n_ref;
        settle(3 * REF_CYC);
        chk(n_ref - r0 >= 2, "R10", "refreshes in power-down", n_ref - r0, 2);
        pd_req = 1'b0;
        settle(12);
        send(0, 2, 8'h5A, 7, '0);
        send(0, 0, 9, 4, '0);
        settle(24);

        chk(exp_q.size() == 0, "R7", "all reads returned", exp_q.size(), 0);
        chk(cyc - m_ref_t <= REF_CYC + MARGIN, "R8", "final refresh gap", cyc - m_ref_t, REF_CYC + MARGIN);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule